// File: doc/BRIEF.md
# Four-Channel Transmit Byte Gearbox

This block sits between wide, slow transmit logic and four serializer channels. On each rising edge of the system clock, every channel captures one word: four data bytes, each with a one-bit control flag. The channel then sends that word as four consecutive 9-bit symbols, one per cycle of its own fast serializer clock. The system clock runs at exactly one quarter of the fast rate. The fast clocks of the four channels are frequency locked to it, but each may have any phase.

Each channel runs a free-running divide-by-four of its fast clock. That divider sets when a captured word is taken across into the fast domain. It also provides a quarter-rate clock. A 2-bit select picks one channel's divided clock and returns it to the slow side. The select code uses a swapped bit order. Captured words cross the clock boundary through two holding slots per channel. The slow side fills the slots in turn, and the fast side empties them in turn. Until the first word has crossed, a channel sends all-zero idle symbols.

Top module: `txGearbox4`

## Requirements
- R1: While reset is asserted, every channel's symbol output is all zeros.
- R2: After reset, a channel sends all-zero idle symbols until the first word captured after reset appears on its output.
- R3: Each symbol carries the control flag in bit 8 and the data byte in bits 7:0. A word is sent in this order: byte 31:24 with flag 3, then byte 23:16 with flag 2, then byte 15:8 with flag 1, then byte 7:0 with flag 0.
- R4: Every word captured on a system clock rising edge appears exactly once, in capture order. Words follow each other with no gap and no repeat.
- R5: The first symbol of each word appears in the fast cycle after the divider phase returns to 0, that is, after a number of fast edges since reset equal to 1 modulo 4.
- R6: The divided clock of each channel comes from a 2-bit phase count that starts at 0 at reset and advances on every fast edge. It is high for phases 0 and 1 and low for phases 2 and 3.
- R7: The returned clock follows one channel's divided clock, chosen by select code {pick[1], pick[0]}: 00 gives channel A, 10 gives channel B, 01 gives channel C, 11 gives channel D.
- R8: Each channel carries only its own slice of the data and flag buses: channel n uses data bits 32n+31:32n, flag bits 4n+3:4n, and symbol bits 9n+8:9n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slowClk | input | 1 | System clock; words are captured on its rising edge |
| fastClk | input | 4 | Per-channel serializer clocks, four times the system clock rate |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| txData | input | 128 | Four bytes per channel, channel n in bits 32n+31:32n |
| txFlag | input | 16 | One control flag per byte, channel n in bits 4n+3:4n |
| clkPick | input | 2 | Code that selects the channel whose divided clock is returned |
| symOut | output | 36 | One 9-bit symbol per channel per fast cycle |
| retClk | output | 1 | Returned quarter-rate clock |

## Verification
Two things happen on the same fast edge. The last symbol of one word leaves the shifter, and the next word is loaded from a holding slot. The stream therefore shows directly whether words run together with no gap or repeat. To provoke this, long random word streams run next to directed all-zero and all-ones words. The four fast clocks are offset from each other and from the system clock by different amounts. Each output symbol is compared with a symbol that the bench builds from the captured words. The bench also checks that each word starts at phase 1. The bench changes the returned-clock select while the channels' dividers are at different counts. It then samples the returned clock just after the selected channel's edge, so that a wrong channel choice shows up as a mismatch.

// File: rtl/txGbPkg.sv
package txGbPkg;
  // strobes passed from a channel's fast-side control to its datapath
  typedef struct packed {
    logic load;    // take the word in rdSlot into the shifter on this edge
    logic rdSlot;  // holding slot to read from
  } gbStrobeT;
endpackage

// File: rtl/gbCtrl.sv
module gbCtrl
  import txGbPkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic     fastClk,
  input  logic     rstN,
  input  logic     startedSlow,
  output gbStrobeT strb,
  output logic     divClk
);
  localparam int PW   = $clog2(BYTES);
  localparam int HALF = BYTES / 2;

  logic [PW-1:0] phase;
  logic          syncA, syncB;
  logic          running;
  logic          rdSlot;
  logic          loadNow;

  assign loadNow     = (phase == '0) && (running || syncB);
  assign strb.load   = loadNow;
  assign strb.rdSlot = rdSlot;
  assign divClk      = (phase < PW'(HALF));

  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      running <= 1'b0;
      rdSlot  <= 1'b0;
    end else begin
      phase <= (phase == PW'(BYTES - 1)) ? '0 : phase + PW'(1);
      syncA <= startedSlow;
      syncB <= syncA;
      if (loadNow) begin
        running <= 1'b1;
        rdSlot  <= ~rdSlot;
      end
    end
  end

  // R5
  start_phase_chk: assert property (@(posedge fastClk) disable iff (!rstN)
    $rose(running) |-> phase == PW'(1));

  // R6
  load_on_rise_chk: assert property (@(posedge fastClk) disable iff (!rstN)
    strb.load |-> $rose(divClk));

  // R4
  running_hold_chk: assert property (@(posedge fastClk) disable iff (!rstN)
    running |=> running);
endmodule

// File: rtl/gbData.sv
module gbData
  import txGbPkg::*;
#(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    slowClk,
  input  logic                    fastClk,
  input  logic                    rstN,
  input  logic [BYTES*BYTE_W-1:0] dataIn,
  input  logic [BYTES-1:0]        flagIn,
  input  gbStrobeT                strb,
  output logic                    startedSlow,
  output logic [BYTE_W:0]         symOut
);
  localparam int SYM_W  = BYTE_W + 1;
  localparam int WORD_W = BYTES * SYM_W;

  logic [WORD_W-1:0] packedW;
  logic [WORD_W-1:0] slot [2];
  logic              wrSlot;
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] loadWord;

  // highest byte lands in the top symbol position, so it is sent first
  for (genvar b = 0; b < BYTES; b++) begin : g_pack
    assign packedW[b*SYM_W +: SYM_W] = {flagIn[b], dataIn[b*BYTE_W +: BYTE_W]};
  end

  // slow side: fill the two holding slots in turn
  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) slot[i] <= '0;
      wrSlot      <= 1'b0;
      startedSlow <= 1'b0;
    end else begin
      slot[wrSlot] <= packedW;
      wrSlot       <= ~wrSlot;
      startedSlow  <= 1'b1;
    end
  end

  assign loadWord = slot[strb.rdSlot];

  // fast side: load on phase 0, shift one symbol per edge otherwise
  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.load) begin
      shiftReg <= loadWord;
    end else begin
      shiftReg <= shiftReg << SYM_W;
    end
  end

  assign symOut = shiftReg[WORD_W-1 -: SYM_W];

  // R3
  load_symbol_chk: assert property (@(posedge fastClk) disable iff (!rstN)
    strb.load |=> symOut == $past(loadWord[WORD_W-1 -: SYM_W]));

  // R4
  shift_next_chk: assert property (@(posedge fastClk) disable iff (!rstN)
    !strb.load |=> symOut == $past(shiftReg[WORD_W-SYM_W-1 -: SYM_W]));
endmodule

// File: rtl/txGearbox4.sv
module txGearbox4
  import txGbPkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int BYTES    = 4,
  parameter int BYTE_W   = 8
) (
  input  logic                                slowClk,
  input  logic [CHANNELS-1:0]                 fastClk,
  input  logic                                rstN,
  input  logic [CHANNELS*BYTES*BYTE_W-1:0]    txData,
  input  logic [CHANNELS*BYTES-1:0]           txFlag,
  input  logic [$clog2(CHANNELS)-1:0]         clkPick,
  output logic [CHANNELS*(BYTE_W+1)-1:0]      symOut,
  output logic                                retClk
);
  localparam int SEL_W  = $clog2(CHANNELS);
  localparam int SYM_W  = BYTE_W + 1;
  localparam int DATA_W = BYTES * BYTE_W;

  logic [CHANNELS-1:0] divAll;
  logic [SEL_W-1:0]    pickIdx;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    gbStrobeT strb;
    logic     startedSlow;
    logic     divClk;

    gbCtrl #(.BYTES(BYTES)) u_ctrl (
      .fastClk    (fastClk[ch]),
      .rstN       (rstN),
      .startedSlow(startedSlow),
      .strb       (strb),
      .divClk     (divClk)
    );

    gbData #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_data (
      .slowClk    (slowClk),
      .fastClk    (fastClk[ch]),
      .rstN       (rstN),
      .dataIn     (txData[ch*DATA_W +: DATA_W]),
      .flagIn     (txFlag[ch*BYTES +: BYTES]),
      .strb       (strb),
      .startedSlow(startedSlow),
      .symOut     (symOut[ch*SYM_W +: SYM_W])
    );

    assign divAll[ch] = divClk;
  end

  // select code is read with its bits swapped
  always_comb begin
    for (int i = 0; i < SEL_W; i++) pickIdx[i] = clkPick[SEL_W-1-i];
  end

  assign retClk = divAll[pickIdx];
endmodule

// File: tb/sim_txGearbox4.sv
module sim_txGearbox4;
  localparam int NW = 160;

  logic         slowClk;
  logic         fc0, fc1, fc2, fc3;
  logic [3:0]   fastClk;
  logic         rstN;
  logic [127:0] txData;
  logic [15:0]  txFlag;
  logic [1:0]   clkPick;
  logic [35:0]  symOut;
  logic         retClk;

  logic [127:0] stD [NW];
  logic [15:0]  stF [NW];
  int           mainChk = 0;
  int           mainBad = 0;

  assign fastClk = {fc3, fc2, fc1, fc0};

  txGearbox4 u0 (
    .slowClk(slowClk), .fastClk(fastClk), .rstN(rstN),
    .txData(txData), .txFlag(txFlag), .clkPick(clkPick),
    .symOut(symOut), .retClk(retClk)
  );

  // fast clocks: 50 MHz, staggered by 5 ns per channel
  initial begin fc0 = 0; forever #10 fc0 = ~fc0; end
  initial begin fc1 = 0; #5;  forever #10 fc1 = ~fc1; end
  initial begin fc2 = 0; #10; forever #10 fc2 = ~fc2; end
  initial begin fc3 = 0; #15; forever #10 fc3 = ~fc3; end
  // system clock at a quarter rate, rising at 42 + 80n ns
  initial begin slowClk = 0; #2; forever #40 slowClk = ~slowClk; end

  function automatic logic [1:0] codeOf(int k);
    return {k[0], k[1]};  // R7 swapped bit order
  endfunction

  // per-channel output and returned-clock checkers
  for (genvar k = 0; k < 4; k++) begin : chk
    logic fck;
    int   edges = 0;
    int   nChk = 0;
    int   nBad = 0;
    bit   begun = 0;
    int   wI = 0;
    int   pI = 0;
    assign fck = fastClk[k];

    function automatic logic [8:0] expSym(int w, int p);
      int b = 3 - p;
      return {stF[w][k*4 + b], stD[w][k*32 + b*8 +: 8]};
    endfunction

    always @(posedge fck) begin
      logic [8:0] s;
      logic [8:0] e;
      if (rstN) edges++;
      #3;
      s = symOut[k*9 +: 9];
      if (clkPick == codeOf(k)) begin
        nChk++;
        if (retClk !== ((edges % 4) < 2)) begin
          nBad++;
          $display("FAIL R7/R6 ch%0d retClk act=%b exp=%b", k, retClk, ((edges % 4) < 2));
        end
      end
      if (!rstN) begin
        nChk++;
        if (s !== 9'd0) begin nBad++; $display("FAIL R1 ch%0d sym act=%h exp=0", k, s); end
      end else if (!begun) begin
        if (s == 9'd0) begin
          nChk++;  // R2 idle
          if (edges > 16) begin nBad++; $display("FAIL R2 ch%0d no start act=0 exp=data by edge 16", k); end
        end else begin
          begun = 1;
          nChk++;
          if (edges % 4 != 1) begin nBad++; $display("FAIL R5 ch%0d start phase act=%0d exp=1", k, edges % 4); end
          e = expSym(0, 0);
          nChk++;
          if (s !== e) begin nBad++; $display("FAIL R3 ch%0d first sym act=%h exp=%h", k, s, e); end
          pI = 1;
        end
      end else if (wI < NW) begin
        if (pI == 0) begin
          nChk++;
          if (edges % 4 != 1) begin nBad++; $display("FAIL R5 ch%0d word %0d phase act=%0d exp=1", k, wI, edges % 4); end
        end
        e = expSym(wI, pI);
        nChk++;
        if (s !== e) begin
          nBad++;
          $display("FAIL R4/R8 ch%0d word %0d sym %0d act=%h exp=%h", k, wI, pI, s, e);
        end
        pI++;
        if (pI == 4) begin pI = 0; wI++; end
      end
    end
  end

  // select changes 2 ns after the system clock edge
  initial begin
    int n = 0;
    clkPick = 2'b00;
    forever begin
      @(posedge slowClk); #2;
      n++;
      if (n % 6 == 0) begin
        if (n < 30) clkPick = codeOf((n / 6) % 4);
        else clkPick = 2'($urandom);
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int w = 0; w < NW; w++) begin
      if (w == 1) begin stD[w] = '0; stF[w] = '0; end
      else if (w == 2) begin stD[w] = '1; stF[w] = '1; end
      else if (w == 3) begin stD[w] = '0; stF[w] = 16'hFFFF; end
      else if (w == 4) begin stD[w] = {4{32'h01234567}}; stF[w] = 16'h5A3C; end
      else begin
        stD[w] = {$urandom, $urandom, $urandom, $urandom};
        stF[w] = 16'($urandom);
      end
    end
    // word 0 has flag 3 set on every channel so its first symbol is nonzero
    stF[0] = stF[0] | 16'h8888;
    rstN = 0;
    txData = stD[0];
    txFlag = stF[0];
    #103 rstN = 1;
    for (int w = 1; w < NW; w++) begin
      @(posedge slowClk); #37;
      txData = stD[w];
      txFlag = stF[w];
    end
    repeat (10) @(posedge slowClk);
    #7;
    for (int k = 0; k < 4; k++) begin
      int got;
      case (k)
        0: got = chk[0].wI;
        1: got = chk[1].wI;
        2: got = chk[2].wI;
        default: got = chk[3].wI;
      endcase
      mainChk++;
      if (got < NW) begin
        mainBad++;
        $display("FAIL R4 ch%0d words seen act=%0d exp=%0d", k, got, NW);
      end
    end
    report();
  end

  task automatic report();
    int t;
    int b;
    t = mainChk + chk[0].nChk + chk[1].nChk + chk[2].nChk + chk[3].nChk;
    b = mainBad + chk[0].nBad + chk[1].nBad + chk[2].nBad + chk[3].nBad;
    $display("  test done: total=%0d bad=%0d", t, b);
    $finish;
  endtask

  initial begin
    #4000000;
    mainChk++;
    mainBad++;
    $display("FAIL watchdog expired act=running exp=finished");
    report();
  end
endmodule